// File: doc/BRIEF.md
# Sensor Clock Divider

This block produces the clock that drives an external image sensor. It takes a master clock, nominally 96 MHz, and a 5-bit divisor code. Codes 2 to 30 divide the master clock by the code value, so code 2 gives 48 MHz and code 30 gives 3.2 MHz. The remaining codes have fixed meanings. Code 0 holds the output low and code 1 holds it high, and in both cases the divider is stopped. Code 31 passes the master clock straight through.

A divisor change never cuts a divided period short. The active code is reloaded only where the output would rise again, so the sensor never sees a runt pulse. Software can therefore rewrite the divisor at any time without waiting for a safe moment. The reset is synchronous and active low.

Top module: `sensor_clk_div`

## Requirements
- R1: With the active code 0, the output stays low on every master cycle.
- R2: With the active code 1, the output stays high on every master cycle.
- R3: With an active code N from 2 to 30, the output is periodic, with a period of exactly N master cycles, and the internal position counter stays below N.
- R4: For an even N, the output is high for N/2 master cycles and then low for N/2 cycles.
- R5: For an odd N, the output is high for (N+1)/2 master cycles and then low for (N-1)/2 cycles.
- R6: With the active code 31, the output follows the master clock level in both halves of every cycle.
- R7: A divisor change made during a divided period does not take effect until that period has completed with the old code. While the active code is 0, 1 or 31, a new code is taken on the next master edge.
- R8: While reset is low, the output is low, the position counter is zero and the active code is 0 after each master edge.
- R9: The master edge that loads a code from 2 to 30 starts a period. The output goes high at that edge and the position counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_code | input | 5 | Requested divisor code: 0 = low, 1 = high, 2..30 = divide, 31 = pass-through |
| clk_out | output | 1 | Clock to the sensor |

## Verification
The divider is exercised in each of the following input patterns:
- Each static code, which shows whether the divider is truly stopped and not just slow.
- The pass-through code, sampled in both clock halves, which separates a real bypass from a divide-by-1 register.
- A set of even and odd divisors, including both ends of the range (2 and 30), whose measured high and low run lengths separate the ceiling and floor rounding of odd codes.

Two further patterns target the load timing:
- A divisor rewrite in the middle of a long period shows whether the old period is allowed to finish.
- A reset pulse in the middle of a period, followed by a divide code, pins down the reset state and the first edge after release.

// File: rtl/sclk_pkg.sv
// Package: shared types for the sensor clock divider.
// Assumes: the divisor code width is chosen at the top level. The mode
// classification does not depend on that width.
package sclk_pkg;

    // Operating class of a divisor code
    typedef enum logic [1:0] {
        SCLK_STATIC_LOW  = 2'd0,
        SCLK_STATIC_HIGH = 2'd1,
        SCLK_DIVIDE      = 2'd2,
        SCLK_PASS        = 2'd3
    } sclk_mode_e;

endpackage

// File: rtl/sclk_mode_decode.sv
// Module: sclk_mode_decode
// Classifies a divisor code into one of four operating classes.
// The all-zero code is static low, the code one is static high, the
// all-ones code is pass-through, and every other code divides.
// Assumes: CODE_W >= 2.
module sclk_mode_decode
    import sclk_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code,
    output sclk_mode_e        mode
);

    localparam logic [CODE_W-1:0] CODE_LOW  = '0;
    localparam logic [CODE_W-1:0] CODE_HIGH = CODE_W'(1);
    localparam logic [CODE_W-1:0] CODE_PASS = '1;

    // Purpose: map the code onto its operating class
    always_comb begin
        if (code == CODE_LOW) begin
            mode = SCLK_STATIC_LOW;
        end else if (code == CODE_HIGH) begin
            mode = SCLK_STATIC_HIGH;
        end else if (code == CODE_PASS) begin
            mode = SCLK_PASS;
        end else begin
            mode = SCLK_DIVIDE;
        end
    end

endmodule

// File: rtl/sclk_period_ctr.sv
// Module: sclk_period_ctr
// Holds the active divisor code, counts the master cycles inside a
// period, and registers the divided output level.
// The requested code is accepted only on a load cycle. A load cycle is the
// last cycle of a divided period, or any cycle while the active code
// is not a divide code.
// Assumes: synchronous active-low reset, and a requested code that is
// already synchronous to clk.
module sclk_period_ctr
    import sclk_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] req_code,
    input  sclk_mode_e        req_mode,
    input  sclk_mode_e        act_mode,
    output logic [CODE_W-1:0] act_code,
    output logic [CODE_W-1:0] pos_q,
    output logic              level_q,
    output logic              load
);

    logic [CODE_W-1:0] last_pos;
    logic [CODE_W-1:0] high_len;
    logic [CODE_W-1:0] pos_nx;

    // Purpose: last position of the period and length of its high phase (ceil N/2)
    always_comb begin
        last_pos = act_code - CODE_W'(1);
        high_len = {1'b0, act_code[CODE_W-1:1]} + {{(CODE_W-1){1'b0}}, act_code[0]};
        pos_nx   = pos_q + CODE_W'(1);
    end

    // Purpose: decide whether this cycle may take a new code
    always_comb begin
        load = (act_mode != SCLK_DIVIDE) || (pos_q == last_pos);
    end

    // Purpose: active code, period position and registered output level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_code <= '0;
            pos_q    <= '0;
            level_q  <= 1'b0;
        end else if (load) begin
            act_code <= req_code;
            pos_q    <= '0;
            level_q  <= (req_mode == SCLK_DIVIDE) || (req_mode == SCLK_STATIC_HIGH);
        end else begin
            pos_q    <= pos_nx;
            level_q  <= (pos_nx < high_len);
        end
    end

endmodule

// File: rtl/sclk_out_sel.sv
// Module: sclk_out_sel
// Selects the sensor clock. In pass-through the master clock itself is
// sent out; in every other mode the registered level is sent out.
// Assumes: pass_en comes from a register clocked by the same master
// clock, so it changes only just after a rising edge.
module sclk_out_sel (
    input  logic clk,
    input  logic pass_en,
    input  logic level,
    output logic clk_out
);

    // Purpose: choose between the master clock and the divided level
    always_comb begin
        clk_out = pass_en ? clk : level;
    end

endmodule

// File: rtl/sensor_clk_div.sv
// Module: sensor_clk_div (top)
// Programmable sensor clock divider. Codes 0 and 1 give static levels,
// codes 2 to 2**CODE_W-2 divide the master clock, and the all-ones code
// passes the master clock through. A divided period always completes
// before a new code is applied.
// Assumes: div_code is synchronous to clk_mst; reset is synchronous, active low.
module sensor_clk_div
    import sclk_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk_mst,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    output logic              clk_out
);

    sclk_mode_e        req_mode;
    sclk_mode_e        act_mode;
    logic [CODE_W-1:0] act_code;
    logic [CODE_W-1:0] pos_q;
    logic              level_q;
    logic              load;
    logic              pass_en;

    // Decoder for the incoming code, used when it is loaded
    sclk_mode_decode #(.CODE_W(CODE_W)) u_dec_req (
        .code (div_code),
        .mode (req_mode)
    );

    // Decoder for the code now in force
    sclk_mode_decode #(.CODE_W(CODE_W)) u_dec_act (
        .code (act_code),
        .mode (act_mode)
    );

    sclk_period_ctr #(.CODE_W(CODE_W)) u_ctr (
        .clk      (clk_mst),
        .rst_n    (rst_n),
        .req_code (div_code),
        .req_mode (req_mode),
        .act_mode (act_mode),
        .act_code (act_code),
        .pos_q    (pos_q),
        .level_q  (level_q),
        .load     (load)
    );

    // Purpose: flag the pass-through class for the output selector
    always_comb begin
        pass_en = (act_mode == SCLK_PASS);
    end

    sclk_out_sel u_sel (
        .clk     (clk_mst),
        .pass_en (pass_en),
        .level   (level_q),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/sclk_div_chk.sv
// Module: sclk_div_chk
// Assertion checker for sensor_clk_div, attached with bind. It observes the
// output, the request, and the active code and position of the period
// counter.
module sclk_div_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_out,
    input logic [CODE_W-1:0] div_code,
    input logic [CODE_W-1:0] act_code,
    input logic [CODE_W-1:0] pos,
    input logic              load
);

    localparam logic [CODE_W-1:0] PASS_CODE = '1;

    logic act_div;
    logic req_div;
    logic [CODE_W:0] act_ceil;

    // Purpose: classify active and requested codes independently of the design
    always_comb begin
        act_div  = (act_code > CODE_W'(1)) && (act_code != PASS_CODE);
        req_div  = (div_code > CODE_W'(1)) && (div_code != PASS_CODE);
        act_ceil = ({1'b0, act_code} + (CODE_W+1)'(1)) >> 1;
    end

    assert_static_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (act_code == '0) |-> !clk_out);

    assert_static_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_code == CODE_W'(1)) |-> clk_out);

    assert_pos_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_div |-> (pos < act_code));

    // Covers R4 and R5: high phase lasts ceil(N/2) positions
    assert_high_phase_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_div |-> (clk_out == ({1'b0, pos} < act_ceil)));

    assert_hold_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != '0) |-> (act_code == $past(act_code)));

    assert_reset_state_R8: assert property (@(posedge clk)
        !rst_n |=> ((pos == '0) && !clk_out && (act_code == '0)));

    assert_load_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && req_div) |=> (clk_out && (pos == '0)));

endmodule

bind sensor_clk_div sclk_div_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk_mst),
    .rst_n    (rst_n),
    .clk_out  (clk_out),
    .div_code (div_code),
    .act_code (act_code),
    .pos      (pos_q),
    .load     (load)
);

// File: tb/sim_sensor_clk_div.sv
// Bench for sensor_clk_div. A behavioural model is compared on both clock
// phases, and measured high and low runs are checked against the requirements.
module sim_sensor_clk_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] div_code = 5'd0;
    logic       clk_out;
    logic       cmp_en = 1'b0;
    logic       done = 1'b0;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    sensor_clk_div #(.CODE_W(5)) u0 (
        .clk_mst  (clk),
        .rst_n    (rst_n),
        .div_code (div_code),
        .clk_out  (clk_out)
    );

    // Behavioural model: active code and position within period
    int m_code = 0;
    int m_pos  = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0;
            m_pos  = 0;
        end else if (m_code < 2 || m_code > 30 || m_pos == m_code - 1) begin
            m_code = int'(div_code);
            m_pos  = 0;
        end else begin
            m_pos++;
        end
    end

    function automatic logic exp_level(logic ck);
        if (m_code == 0) return 1'b0;
        if (m_code == 1) return 1'b1;
        if (m_code == 31) return ck;
        return (2 * m_pos < m_code);
    endfunction

    function automatic string tag_of(int code);
        if (code == 0) return "R1";
        if (code == 1) return "R2";
        if (code == 31) return "R6";
        return "R3";
    endfunction

    task automatic check(logic ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-phase comparison with the model
    initial begin
        wait (cmp_en);
        forever begin
            @(posedge clk); #2;
            check(clk_out === exp_level(1'b1), tag_of(m_code), int'(clk_out), int'(exp_level(1'b1)));
            @(negedge clk); #2;
            check(clk_out === exp_level(1'b0), tag_of(m_code), int'(clk_out), int'(exp_level(1'b0)));
        end
    end

    task automatic sync_rise();
        int g = 0;
        logic v;
        do begin @(posedge clk); #2; v = clk_out; g++; end while (v !== 1'b0 && g < 100);
        do begin @(posedge clk); #2; v = clk_out; g++; end while (v !== 1'b1 && g < 200);
    endtask

    // Called just after a rising sample; returns at the next rising sample
    task automatic measure_from_rise(output int hi, output int lo);
        logic v;
        hi = 1;
        lo = 0;
        for (int g = 0; g < 100; g++) begin
            @(posedge clk); #2; v = clk_out;
            if (v === 1'b1) begin
                if (lo != 0) break;
                hi++;
            end else begin
                lo++;
            end
        end
    endtask

    task automatic set_code(int c);
        @(negedge clk);
        div_code = 5'(c);
    endtask

    initial begin
        int hi, lo;
        int codes[7] = '{2, 3, 4, 7, 8, 15, 30};
        repeat (3) @(posedge clk);
        #2;
        check(clk_out === 1'b0, "R8", int'(clk_out), 0);
        cmp_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (12) @(posedge clk);              // R1: code 0 held low
        set_code(1);  repeat (12) @(posedge clk); // R2: static high
        set_code(31); repeat (12) @(posedge clk); // R6: pass-through
        for (int i = 0; i < 7; i++) begin
            int n = codes[i];
            set_code(n);
            sync_rise();
            for (int p = 0; p < 2; p++) begin
                measure_from_rise(hi, lo);
                check(hi + lo == n, "R3", hi + lo, n);
                if (n % 2 == 0) begin
                    check(hi == n / 2, "R4", hi, n / 2);
                    check(lo == n / 2, "R4", lo, n / 2);
                end else begin
                    check(hi == (n + 1) / 2, "R5", hi, (n + 1) / 2);
                    check(lo == (n - 1) / 2, "R5", lo, (n - 1) / 2);
                end
            end
        end
        // R7: change from 10 to 4 one cycle into a period
        set_code(10);
        sync_rise();
        @(negedge clk);
        div_code = 5'd4;
        measure_from_rise(hi, lo);
        check(hi == 5, "R7", hi, 5);
        check(lo == 5, "R7", lo, 5);
        measure_from_rise(hi, lo);
        check(hi == 2, "R7", hi, 2);
        check(lo == 2, "R7", lo, 2);
        // R8 and R9: reset mid-period, then restart with code 6
        set_code(6);
        sync_rise();
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #2;
        check(clk_out === 1'b0, "R8", int'(clk_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(clk_out === 1'b1, "R9", int'(clk_out), 1);
        measure_from_rise(hi, lo);
        check(hi == 3 && lo == 3, "R9", hi * 10 + lo, 33);
        // Back to static low: takes effect at period end
        set_code(0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3: watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule